// File: doc/BRIEF.md
# Serial Volume-Control Register Interface

This block sits in front of a multichannel volume controller and turns a slow serial control stream into the codes that drive one master attenuator and a set of channel gain stages. A host shifts bytes in on a serial clock and a data line while an active-low write enable, which acts as a chip select, is held low. Each byte is either an address byte or a data byte, and its most significant bit says which. An address byte picks a target register. The target stays selected, so any number of data bytes can follow it, in the same frame or in later frames.

Data bytes first land in shadow registers. The held codes and mute flags on the outputs change only when an active-low load strobe rises. In four-wire use the load strobe is pulsed on its own after write has risen. In three-wire use the host ties load to write, so the rising edge of write performs the transfer.

All serial inputs are asynchronous. Each one passes through a two-flop synchroniser, and the system clock detects edges on the synchronised samples. The system clock must run at least four times faster than the serial clock.

Top module: `vcs_top`

## Requirements
- R1: After reset, master_code is 7'h00 and master_mute is 1. Every 5-bit channel code is 5'h1F and every bit of ch_mute is 0.
- R2: A byte is captured MSB first, one bit on each falling edge of sclk while wr_n is low. Capture works the same whether sclk idles high or idles low.
- R3: A byte with bit 7 set to 1 is an address byte. Bits 2:0 select the target: 0 selects the master, 1 to 6 select channels 1 to 6, and 7 selects nothing. Bits 6:3 are ignored.
- R4: A byte with bit 7 set to 0 is a data byte for the most recently addressed target. The address stays latched across data bytes and across frames, so the last data byte sent before a load is the one that appears.
- R5: For the master, bits 6:0 of the data byte form the code (7'h7F is 0 dB and 7'h00 is 127 dB of attenuation). Loading a master data byte clears master_mute, and master_mute never becomes 1 again until reset.
- R6: For a channel, bits 4:0 of the data byte form the code (5'h00 is +31 dB, 5'h1F is 0 dB and 5'h10 is the balance centre). Bit 5 is the unmute flag: 0 sets that channel's ch_mute bit to 1 and 1 clears it. Channel n occupies ch_code bits [5n-1:5n-5] and ch_mute bit n-1.
- R7: The outputs change only on a rising edge of ld_n. Bytes that are shifted in without a load leave the outputs unchanged, and a later ld_n pulse then transfers them.
- R8: When ld_n is driven together with wr_n (three-wire use), the rising edge of wr_n transfers the frame's data to the outputs.
- R9: Edges on sclk while wr_n is high are ignored. A partial byte left when wr_n rises is discarded, and the next frame starts on a byte boundary.
- R10: Data bytes sent while the "nothing selected" address (bits 2:0 = 7) is latched change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, asynchronous, bits captured on its falling edge |
| sdata | input | 1 | Serial data, MSB first |
| wr_n | input | 1 | Active-low write enable / chip select |
| ld_n | input | 1 | Active-low load strobe, transfer on its rising edge |
| master_code | output | MASTER_W | Held master attenuation code |
| master_mute | output | 1 | Master mute, 1 = muted |
| ch_code | output | NUM_CH*CH_W | Held channel gain codes, channel 1 in the lowest bits |
| ch_mute | output | NUM_CH | Channel mute flags, 1 = muted, channel 1 in bit 0 |

## Verification
The bench builds the block with its default parameters: six channels, a 7-bit master code, 5-bit channel codes, an 8-bit byte and a 3-bit address field. These values make every address code reachable, including the unused code 7. They also leave room in the channel data byte for the mute flag just above the 5-bit code. One serial bit lasts twenty system clocks, so both sclk idle levels and the synchroniser edge detection are exercised well inside the required sampling margin.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
  parameter int VCS_BYTE_W   = 8;
  parameter int VCS_ADDR_W   = 3;
  parameter int VCS_MASTER_W = 7;
  parameter int VCS_CH_W     = 5;
  parameter int VCS_NUM_CH   = 6;
  parameter int VCS_SYNC_N   = 2;
endpackage

// File: rtl/vcs_sync.sv
module vcs_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] st [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) st[s] <= RST_VAL;
        else if (s == 0) st[s] <= d_in;
        else st[s] <= st[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign d_out = st[STAGES-1];
endmodule

// File: rtl/vcs_shift.sv
module vcs_shift #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdata_s,
  input  logic              wr_n_s,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_out
);
  logic             sclk_q;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic             fall;

  assign fall = sclk_q & ~sclk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      sh       <= '0;
      cnt      <= '0;
      byte_vld <= 1'b0;
      byte_out <= '0;
    end else begin
      sclk_q   <= sclk_s;
      byte_vld <= 1'b0;
      if (wr_n_s) begin
        cnt <= '0;
      end else if (fall) begin
        sh <= {sh[BYTE_W-2:0], sdata_s};
        if (cnt == CNT_W'(BYTE_W-1)) begin
          cnt      <= '0;
          byte_vld <= 1'b1;
          byte_out <= {sh[BYTE_W-2:0], sdata_s};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_n_s |=> (cnt == '0 && !byte_vld));

  // R2
  byte_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld);
endmodule

// File: rtl/vcs_stage.sv
module vcs_stage #(
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int MASTER_W = 7,
  parameter int CH_W     = 5,
  parameter int NUM_CH   = 6,
  localparam int CV_W    = NUM_CH * CH_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                byte_vld,
  input  logic [BYTE_W-1:0]   byte_in,
  output logic [MASTER_W-1:0] sh_m,
  output logic                sh_mm,
  output logic [CV_W-1:0]     sh_c,
  output logic [NUM_CH-1:0]   sh_cm
);
  localparam logic [ADDR_W-1:0] ADDR_NONE = '1;

  logic [ADDR_W-1:0] addr_q;
  logic              is_addr;

  assign is_addr = byte_in[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= ADDR_NONE;
      sh_m   <= '0;
      sh_mm  <= 1'b1;
      sh_c   <= '1;
      sh_cm  <= '0;
    end else if (byte_vld) begin
      if (is_addr) begin
        addr_q <= byte_in[ADDR_W-1:0];
      end else begin
        if (addr_q == '0) begin
          sh_m  <= byte_in[MASTER_W-1:0];
          sh_mm <= 1'b0;
        end
        for (int i = 0; i < NUM_CH; i++) begin
          if (addr_q == ADDR_W'(i+1)) begin
            sh_c[i*CH_W +: CH_W] <= byte_in[CH_W-1:0];
            sh_cm[i]             <= ~byte_in[CH_W];
          end
        end
      end
    end
  end

  // R3
  addr_byte_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && is_addr) |=> ($stable(sh_m) && $stable(sh_c) && $stable(sh_cm) && $stable(sh_mm)));

  // R10
  none_sel_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !is_addr && addr_q == ADDR_NONE) |=> ($stable(sh_m) && $stable(sh_c) && $stable(sh_cm) && $stable(sh_mm)));

  // R4
  data_keeps_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !is_addr) |=> $stable(addr_q));
endmodule

// File: rtl/vcs_hold.sv
module vcs_hold #(
  parameter int MASTER_W = 7,
  parameter int CH_W     = 5,
  parameter int NUM_CH   = 6,
  localparam int CV_W    = NUM_CH * CH_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [MASTER_W-1:0] sh_m,
  input  logic                sh_mm,
  input  logic [CV_W-1:0]     sh_c,
  input  logic [NUM_CH-1:0]   sh_cm,
  output logic [MASTER_W-1:0] master_code,
  output logic                master_mute,
  output logic [CV_W-1:0]     ch_code,
  output logic [NUM_CH-1:0]   ch_mute
);
  always_ff @(posedge clk) begin
    if (rst) begin
      master_code <= '0;
      master_mute <= 1'b1;
      ch_code     <= '1;
      ch_mute     <= '0;
    end else if (load) begin
      master_code <= sh_m;
      master_mute <= sh_mm;
      ch_code     <= sh_c;
      ch_mute     <= sh_cm;
    end
  end

  // R7
  hold_without_load_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(master_code) && $stable(master_mute) && $stable(ch_code) && $stable(ch_mute)));

  // R5
  master_mute_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(master_mute));
endmodule

// File: rtl/vcs_top.sv
module vcs_top
  import vcs_pkg::*;
#(
  parameter int BYTE_W   = VCS_BYTE_W,
  parameter int ADDR_W   = VCS_ADDR_W,
  parameter int MASTER_W = VCS_MASTER_W,
  parameter int CH_W     = VCS_CH_W,
  parameter int NUM_CH   = VCS_NUM_CH,
  parameter int SYNC_N   = VCS_SYNC_N,
  localparam int CV_W    = NUM_CH * CH_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk,
  input  logic                sdata,
  input  logic                wr_n,
  input  logic                ld_n,
  output logic [MASTER_W-1:0] master_code,
  output logic                master_mute,
  output logic [CV_W-1:0]     ch_code,
  output logic [NUM_CH-1:0]   ch_mute
);
  logic [3:0] raw_in, syn;
  logic       ld_q, load;
  logic       byte_vld;
  logic [BYTE_W-1:0]   byte_q;
  logic [MASTER_W-1:0] sh_m;
  logic                sh_mm;
  logic [CV_W-1:0]     sh_c;
  logic [NUM_CH-1:0]   sh_cm;

  assign raw_in = {ld_n, wr_n, sdata, sclk};

  vcs_sync #(.W(4), .STAGES(SYNC_N), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst(rst), .d_in(raw_in), .d_out(syn)
  );

  always_ff @(posedge clk) begin
    if (rst) ld_q <= 1'b1;
    else     ld_q <= syn[3];
  end
  assign load = syn[3] & ~ld_q;

  vcs_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .sclk_s(syn[0]), .sdata_s(syn[1]), .wr_n_s(syn[2]),
    .byte_vld(byte_vld), .byte_out(byte_q)
  );

  vcs_stage #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .MASTER_W(MASTER_W),
              .CH_W(CH_W), .NUM_CH(NUM_CH)) u_stage (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_q),
    .sh_m(sh_m), .sh_mm(sh_mm), .sh_c(sh_c), .sh_cm(sh_cm)
  );

  vcs_hold #(.MASTER_W(MASTER_W), .CH_W(CH_W), .NUM_CH(NUM_CH)) u_hold (
    .clk(clk), .rst(rst), .load(load),
    .sh_m(sh_m), .sh_mm(sh_mm), .sh_c(sh_c), .sh_cm(sh_cm),
    .master_code(master_code), .master_mute(master_mute),
    .ch_code(ch_code), .ch_mute(ch_mute)
  );

  // R8
  load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);
endmodule

// File: tb/sim_vcs_top.sv
`timescale 1ns/1ps
module sim_vcs_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, wr_n = 1'b1, ld_n = 1'b1;
  logic [6:0]  master_code;
  logic        master_mute;
  logic [29:0] ch_code;
  logic [5:0]  ch_mute;

  always #2 clk = ~clk;

  vcs_top u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .wr_n(wr_n), .ld_n(ld_n),
    .master_code(master_code), .master_mute(master_mute),
    .ch_code(ch_code), .ch_mute(ch_mute)
  );

  typedef struct {
    string       tag;
    logic [6:0]  m;
    logic        mm;
    logic [29:0] c;
    logic [5:0]  cm;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit idle_hi = 1'b0;
  bit reported = 1'b0;

  logic [6:0]  e_m  = 7'h00;
  logic        e_mm = 1'b1;
  logic [29:0] e_c  = '1;
  logic [5:0]  e_cm = '0;

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic chk(string tag, string fld, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
    end
  endtask

  task automatic set_ch(int n, logic [4:0] code, logic muted);
    e_c[(n-1)*5 +: 5] = code;
    e_cm[n-1] = muted;
  endtask

  task automatic expect_now(string tag);
    exp_t e;
    e.tag = tag; e.m = e_m; e.mm = e_mm; e.c = e_c; e.cm = e_cm;
    q.push_back(e);
    #200;
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdata = b[i];
      if (idle_hi) begin
        #40 sclk = 1'b0;
        #40 sclk = 1'b1;
      end else begin
        sclk = 1'b1;
        #40 sclk = 1'b0;
        #40;
      end
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic fb(bit three);
    wr_n = 1'b0;
    if (three) ld_n = 1'b0;
    #40;
  endtask

  task automatic pulse_ld();
    #40 ld_n = 1'b0;
    #80 ld_n = 1'b1;
    #40;
  endtask

  task automatic fe(bit three, bit do_load);
    #40;
    wr_n = 1'b1;
    if (three) ld_n = 1'b1;
    else if (do_load) pulse_ld();
    #40;
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      wait (q.size() > 0);
      repeat (12) @(negedge clk);
      e = q.pop_front();
      chk(e.tag, "master_code", {25'd0, master_code}, {25'd0, e.m});
      chk(e.tag, "master_mute", {31'd0, master_mute}, {31'd0, e.mm});
      chk(e.tag, "ch_code", {2'd0, ch_code}, {2'd0, e.c});
      chk(e.tag, "ch_mute", {26'd0, ch_mute}, {26'd0, e.cm});
    end
  end

  // watchdog
  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  // driver
  initial begin
    #1;
    #40 rst = 1'b0;
    #40;
    expect_now("R1 reset state");

    // R5 R2: master write, idle-low clock, four-wire
    fb(0); send_byte(8'h80); send_byte(8'h55); fe(0, 1);
    e_m = 7'h55; e_mm = 1'b0;
    expect_now("R5 R2 master write");

    // R6: channel 1 code 0A unmuted
    fb(0); send_byte(8'h81); send_byte(8'h2A); fe(0, 1);
    set_ch(1, 5'h0A, 1'b0);
    expect_now("R6 ch1 unmuted");

    // R3: don't-care address bits, ch3 muted code 05
    fb(0); send_byte(8'hFB); send_byte(8'h05); fe(0, 1);
    set_ch(3, 5'h05, 1'b1);
    expect_now("R3 R6 ch3 muted");

    // R4: two data bytes to ch6, last wins
    fb(0); send_byte(8'h86); send_byte(8'h31); send_byte(8'h3E); fe(0, 1);
    set_ch(6, 5'h1E, 1'b0);
    expect_now("R4 ch6 repeated data");

    // R2: idle-high clock, ch2 balance centre
    idle_hi = 1'b1; sclk = 1'b1; #40;
    fb(0); send_byte(8'h82); send_byte(8'h30); fe(0, 1);
    set_ch(2, 5'h10, 1'b0);
    expect_now("R2 idle-high ch2");
    idle_hi = 1'b0; sclk = 1'b0; #40;

    // R7: no load -> unchanged, then load
    fb(0); send_byte(8'h84); send_byte(8'h21); fe(0, 0);
    expect_now("R7 no load no change");
    pulse_ld();
    set_ch(4, 5'h01, 1'b0);
    expect_now("R7 later load transfers");

    // R8: three-wire, two targets in one frame
    fb(1); send_byte(8'h85); send_byte(8'h3F); send_byte(8'h80); send_byte(8'h7F); fe(1, 0);
    set_ch(5, 5'h1F, 1'b0);
    e_m = 7'h7F;
    expect_now("R8 three-wire transfer");

    // R10: nothing selected
    fb(0); send_byte(8'h87); send_byte(8'h00); send_byte(8'h20); fe(0, 1);
    expect_now("R10 none selected");

    // R9: sclk toggles with wr_n high are ignored
    send_byte(8'h81); send_byte(8'h00);
    pulse_ld();
    expect_now("R9 write high ignored");

    // R9: partial byte discarded
    fb(0); send_byte(8'h81); send_bits(8'hFF, 4); fe(0, 1);
    expect_now("R9 partial discarded");
    fb(0); send_byte(8'h2B); fe(0, 1);
    set_ch(1, 5'h0B, 1'b0);
    expect_now("R9 R4 byte aligned after partial");

    // R5: master code 00 keeps mute cleared
    fb(0); send_byte(8'h80); send_byte(8'h00); fe(0, 1);
    e_m = 7'h00;
    expect_now("R5 master max atten unmuted");

    wait (q.size() == 0);
    repeat (20) @(negedge clk);
    report();
  end
endmodule